// File: doc/BRIEF.md
# I2C Slave Front End with Persistent Register Pointer

This block is the serial side of an 8-bit GPIO expander. It takes the raw SCL and SDA levels sampled in the system clock domain and cleans them with a stable-count filter. It finds START and STOP conditions and checks the incoming 7-bit slave address. It then talks to an external register bank through a plain port: a register address, a one-clock write strobe with write data, and a one-clock read strobe with read data returned in the same cycle. The block answers on SDA only through an open-drain enable. When `sda_oe` is high, the pad pulls the line low.

In a write transfer, the first byte after the address is a command byte. It is kept as a register pointer. Every further byte in that transfer is written to the pointed register. The pointer survives STOP, so a later read transfer needs no command byte. Each byte of that read returns a fresh sample of the same register. The read strobe marks the moment the sample is taken. A `busy` flag shows that a transfer addressed to this slave is in progress. A timeout monitor can pulse `soft_rst` to drop the transfer and free the bus.

Top module: `i2c_ptr_slave`

## Requirements
- R1: After reset, `sda_oe`, `busy`, `reg_wr` and `reg_rd` are low and `reg_addr` is 0x00.
- R2: The slave address is `{1'b0, slave_id}`. Bit 0 of the address byte selects the direction (0 = write, 1 = read). On a match, the slave drives SDA low through the 9th clock of the address byte, and `busy` is high from then until the transfer ends.
- R3: An address byte that does not match gets no acknowledge. After it, `busy` is low, `sda_oe` is never asserted, and no strobe is issued until the next START.
- R4: In a write transfer, the byte after the address is acknowledged and appears on `reg_addr` as the pointer.
- R5: Each further byte in a write transfer is acknowledged. After its ACK clock falls, `reg_wr` pulses for one clock with that byte on `reg_wdata` and the unchanged pointer on `reg_addr`. Several bytes in one transfer all go to the same register.
- R6: In a read transfer, `reg_rd` pulses for one clock at the start of each byte sent. The slave sends the `reg_rdata` value present during that pulse, MSB first. The pointer kept from an earlier transfer selects the register.
- R7: A master ACK (SDA low on the 9th clock of a read byte) starts another byte, sampled fresh. A master NACK releases SDA, issues no further read strobe, and ends the transfer (`busy` low).
- R8: A STOP at any point returns the block to idle. A partly received byte is discarded and produces no write strobe. The pointer is kept.
- R9: A repeated START without a STOP restarts address reception. A read can then follow a command byte in the same bus sequence.
- R10: A pulse on SCL or SDA lasting fewer than `FILT_LEN` system clocks has no effect. It causes no false START, no false STOP and no extra bit.
- R11: A `soft_rst` pulse returns the block to idle on the next clock, with `sda_oe` and `busy` low. The pointer is kept.
- R12: `sda_oe` changes only while SCL is low, except in the clock after `soft_rst`.
- R13: `reg_wr` and `reg_rd` are single-clock pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Drop the current transfer (from the timeout monitor) |
| slave_id | input | 6 | Strapped low six bits of the slave address |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level (the wired bus line) |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | A transfer addressed to this slave is active |
| reg_addr | output | 8 | Register pointer |
| reg_wr | output | 1 | One-clock write strobe |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rd | output | 1 | One-clock read-sample strobe |
| reg_rdata | input | 8 | Register contents, valid in the `reg_rd` cycle |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the strobes are single clocks and never overlap;
- the pointer is stable under a write strobe;
- the block stays quiet while not busy;
- it recovers after `soft_rst`;
- SDA is only driven while SCL is low.

The directed scenarios cover what depends on a bus sequence: the address match and mismatch, the pointer carried over from one transfer to the next, latching of read data at the strobe rather than at the later bit times, ACK and NACK handling by the master, discarding of a partial byte at STOP, the repeated START, and rejection of glitches.

// File: rtl/i2c_ptr_pkg.sv
// Shared types and constants for the I2C pointer slave.
package i2c_ptr_pkg;

    localparam int BYTE_W    = 8;   // bits per bus byte
    localparam int BIT_CNT_W = 4;   // counts 0..8 bits
    localparam int NUM_LINES = 2;   // SCL and SDA

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } xfer_state_t;

endpackage

// File: rtl/i2c_glitch_filter.sv
// Synchronizer plus stable-count filter for one bus line.
// Assumes: SYNC_STAGES >= 2. The output follows the input only after
// FILT_LEN consecutive samples that differ from the current output.
// The idle output level is high, as on a pulled-up bus.
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    // Accept a new level only after it has held for FILT_LEN samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= 1'b1;
            cnt_q <= '0;
        end else if (sync_q[SYNC_STAGES-1] == dout) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            dout  <= sync_q[SYNC_STAGES-1];
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/i2c_bus_cond.sv
// Edge and bus-condition detector on the filtered SCL and SDA.
// Assumes: the inputs are already synchronous and free of glitches.
// Each output is a one-clock pulse.
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q, sda_q;

    // Hold the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // SDA edges while SCL stays high are START and STOP.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/i2c_ptr_fsm.sv
// Byte-level protocol engine: address match, command pointer,
// write and read data bytes, and the ACK/NACK handling.
// Assumes: single-clock edge and condition pulses from i2c_bus_cond.
// reg_rdata is valid in the cycle where reg_rd is high.
module i2c_ptr_fsm
    import i2c_ptr_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ID_W-1:0]   slave_id,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              busy,
    output logic [BYTE_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam int ADDR_W = BYTE_W - 1;
    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

    xfer_state_t          state_q;
    logic [BIT_CNT_W-1:0] bit_cnt_q;
    logic [BYTE_W-1:0]    rx_q;
    logic [BYTE_W-1:0]    tx_q;
    logic                 rw_q;
    logic                 mack_q;
    logic [ADDR_W-1:0]    own_addr;

    // The slave address is the strapped id with the top bit forced to zero.
    assign own_addr = ADDR_W'(slave_id);
    assign busy     = (state_q != ST_IDLE);

    // Protocol sequencing; abort sources take priority over bus edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            sda_oe    <= 1'b0;
            reg_addr  <= '0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (soft_rst) begin
                state_q <= ST_IDLE;
                sda_oe  <= 1'b0;
            end else if (start_det) begin
                state_q   <= ST_ADDR;
                bit_cnt_q <= '0;
                sda_oe    <= 1'b0;
            end else if (stop_det) begin
                state_q <= ST_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                // Latch the register sample in the strobe cycle and put out its MSB.
                if (reg_rd && state_q == ST_RDATA) begin
                    tx_q   <= {reg_rdata[BYTE_W-2:0], 1'b0};
                    sda_oe <= ~reg_rdata[BYTE_W-1];
                end
                case (state_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise && bit_cnt_q != FULL_CNT) begin
                            rx_q      <= {rx_q[BYTE_W-2:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall && bit_cnt_q == FULL_CNT) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (rx_q[BYTE_W-1:1] == own_addr) begin
                                    rw_q    <= rx_q[0];
                                    sda_oe  <= 1'b1;
                                    state_q <= ST_ADDR_ACK;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else if (state_q == ST_CMD) begin
                                reg_addr <= rx_q;
                                sda_oe   <= 1'b1;
                                state_q  <= ST_CMD_ACK;
                            end else begin
                                reg_wdata <= rx_q;
                                sda_oe    <= 1'b1;
                                state_q   <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                reg_rd  <= 1'b1;
                                state_q <= ST_RDATA;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            state_q <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            reg_wr  <= 1'b1;
                            state_q <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt_q == FULL_CNT) begin
                                sda_oe    <= 1'b0;
                                bit_cnt_q <= '0;
                                state_q   <= ST_RDATA_ACK;
                            end else begin
                                sda_oe <= ~tx_q[BYTE_W-1];
                                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_f;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                reg_rd  <= 1'b1;
                                state_q <= ST_RDATA;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_ptr_slave.sv
// Top of the I2C slave front end: per-line glitch filters, the bus
// condition detector and the protocol engine.
// Assumes: clk runs at least 8x the SCL rate, and FILT_LEN clock periods
// exceed the longest spike to be rejected.
module i2c_ptr_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int ID_W        = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic [ID_W-1:0] slave_id,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            sda_oe,
    output logic            busy,
    output logic [7:0]      reg_addr,
    output logic            reg_wr,
    output logic [7:0]      reg_wdata,
    output logic            reg_rd,
    input  logic [7:0]      reg_rdata
);

    import i2c_ptr_pkg::*;

    logic [NUM_LINES-1:0] raw_w, filt_w;
    logic scl_rise, scl_fall, start_det, stop_det;

    // Line 0 is SCL, line 1 is SDA.
    assign raw_w = {sda_in, scl_in};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
        i2c_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_w[g]),
            .dout (filt_w[g])
        );
    end

    i2c_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_w[0]),
        .sda_f    (filt_w[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_ptr_fsm #(
        .ID_W(ID_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .slave_id (slave_id),
        .sda_f    (filt_w[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_oe   (sda_oe),
        .busy     (busy),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rd   (reg_rd),
        .reg_rdata(reg_rdata)
    );

endmodule

// File: rtl/i2c_ptr_slave_chk.sv
// Protocol checker bound to i2c_ptr_slave; it observes the ports only.
module i2c_ptr_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       busy,
    input logic [7:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd
);

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);                                           // R13
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);                                           // R13
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));                                          // R13
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sda_oe && !reg_wr));                               // R3
    AST_WR_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (busy && $stable(reg_addr)));                       // R5
    AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !sda_oe));                              // R11
    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(soft_rst)) |-> !scl_in);           // R12

endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .scl_in  (scl_in),
    .sda_oe  (sda_oe),
    .busy    (busy),
    .reg_addr(reg_addr),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd)
);

// File: tb/tb_i2c_ptr_slave.sv
// Directed bench: a bit-level bus master, a small register bank model
// and one task for each scenario.
module tb_i2c_ptr_slave;

    localparam int Q = 25;   // quarter SCL period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [5:0] slave_id = 6'h15;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe, busy, reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] port_in = 8'h00;
    logic [7:0] regs [8];
    logic       glitch_en = 1'b0;
    logic       done = 1'b0;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         wr_cnt = 0;
    int         rd_cnt = 0;
    logic [7:0] w_addr = 8'h00;
    logic [7:0] w_data = 8'h00;

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = (reg_addr == 8'h00) ? port_in : regs[reg_addr[2:0]];

    i2c_ptr_slave dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .slave_id(slave_id),
        .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe), .busy(busy),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // Register bank model; it also counts strobes.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) regs[i] = 8'h10 + 8'(i);
        end else begin
            if (reg_wr) begin
                wr_cnt++;
                w_addr = reg_addr;
                w_data = reg_wdata;
                regs[reg_addr[2:0]] = reg_wdata;
            end
            if (reg_rd) rd_cnt++;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();   // also serves as a repeated START
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1;
        if (glitch_en) begin
            repeat (5) @(negedge clk); scl_m = 1'b0;
            repeat (2) @(negedge clk); scl_m = 1'b1;
            repeat (5) @(negedge clk); sda_m = ~b;
            repeat (2) @(negedge clk); sda_m = b;
            repeat (2*Q-14) @(negedge clk);
        end else begin
            repeat (2*Q) @(negedge clk);
        end
        scl_m = 1'b0; wait_q();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack = ~sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wait_q();
            scl_m = 1'b1; wait_q();
            d = {d[6:0], sda_line}; wait_q();
            scl_m = 1'b0; wait_q();
        end
        send_bit(~give_ack);
    endtask

    task automatic t_reset();
        check("R1 sda_oe after reset", 32'(sda_oe), 0);
        check("R1 busy after reset", 32'(busy), 0);
        check("R1 strobes after reset", 32'({reg_wr, reg_rd}), 0);
        check("R1 pointer after reset", 32'(reg_addr), 0);
    endtask

    task automatic t_write();
        logic ack;
        bus_start();
        write_byte(8'h2A, ack);
        check("R2 address ack", 32'(ack), 1);
        check("R2 busy after match", 32'(busy), 1);
        write_byte(8'h03, ack);
        check("R4 command ack", 32'(ack), 1);
        check("R4 pointer", 32'(reg_addr), 8'h03);
        write_byte(8'hA5, ack);
        check("R5 data ack", 32'(ack), 1);
        check("R5 one strobe", 32'(wr_cnt), 1);
        check("R5 write data", 32'({w_addr, w_data}), 16'h03A5);
        write_byte(8'h3C, ack);
        check("R5 second strobe", 32'(wr_cnt), 2);
        check("R5 same register", 32'({w_addr, w_data}), 16'h033C);
        bus_stop();
        check("R8 busy after stop", 32'(busy), 0);
    endtask

    task automatic t_read_ptr();
        logic ack;
        logic [7:0] d;
        int rd0;
        rd0 = rd_cnt;
        bus_start();
        write_byte(8'h2B, ack);
        check("R2 read address ack", 32'(ack), 1);
        read_byte(1'b1, d);
        check("R6 kept pointer read", 32'(d), 8'h3C);
        read_byte(1'b0, d);
        check("R7 repeat byte", 32'(d), 8'h3C);
        check("R6 read strobes", 32'(rd_cnt - rd0), 2);
        bus_stop();
    endtask

    task automatic t_read_fresh();
        logic ack;
        logic [7:0] d;
        int rd0;
        bus_start(); write_byte(8'h2A, ack); write_byte(8'h00, ack); bus_stop();
        port_in = 8'h5A;
        rd0 = rd_cnt;
        bus_start();
        write_byte(8'h2B, ack);
        port_in = 8'hC3;   // changed after the first strobe
        read_byte(1'b1, d);
        check("R6 latched at strobe", 32'(d), 8'h5A);
        read_byte(1'b0, d);
        check("R7 fresh sample", 32'(d), 8'hC3);
        check("R7 NACK ends busy", 32'(busy), 0);
        check("R7 NACK releases SDA", 32'(sda_oe), 0);
        check("R7 no strobe after NACK", 32'(rd_cnt - rd0), 2);
        bus_stop();
    endtask

    task automatic t_soft_rst();
        logic ack;
        logic [7:0] d;
        port_in = 8'h00;
        bus_start();
        write_byte(8'h2B, ack);
        check("R6 drives low bit", 32'(sda_oe), 1);
        soft_rst = 1'b1; @(negedge clk);
        soft_rst = 1'b0;
        check("R11 SDA released", 32'(sda_oe), 0);
        check("R11 busy dropped", 32'(busy), 0);
        bus_stop();
        port_in = 8'h7E;
        bus_start(); write_byte(8'h2B, ack);
        read_byte(1'b0, d);
        check("R11 pointer kept", 32'(d), 8'h7E);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic ack;
        int w0;
        logic [7:0] p0;
        w0 = wr_cnt; p0 = reg_addr;
        bus_start();
        write_byte(8'hAA, ack);   // top address bit set: not ours
        check("R3 no ack", 32'(ack), 0);
        check("R3 not busy", 32'(busy), 0);
        write_byte(8'h01, ack);
        check("R3 later byte ignored", 32'(ack), 0);
        check("R3 no write", 32'(wr_cnt - w0), 0);
        check("R3 pointer unchanged", 32'(reg_addr), 32'(p0));
        bus_stop();
    endtask

    task automatic t_stop_partial();
        logic ack;
        int w0;
        w0 = wr_cnt;
        bus_start();
        write_byte(8'h2A, ack);
        write_byte(8'h05, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        check("R8 partial byte dropped", 32'(wr_cnt - w0), 0);
        check("R8 idle after stop", 32'(busy), 0);
        check("R8 pointer kept", 32'(reg_addr), 8'h05);
    endtask

    task automatic t_rep_start();
        logic ack;
        logic [7:0] d;
        bus_start();
        write_byte(8'h2A, ack);
        write_byte(8'h02, ack);
        bus_start();
        write_byte(8'h2B, ack);
        check("R9 address after repeated start", 32'(ack), 1);
        read_byte(1'b0, d);
        check("R9 read after repeated start", 32'(d), 8'h12);
        bus_stop();
    endtask

    task automatic t_glitch();
        logic ack;
        int w0;
        sda_m = 1'b0; repeat (2) @(negedge clk); sda_m = 1'b1;
        repeat (20) @(negedge clk);
        check("R10 SDA spike no start", 32'(busy), 0);
        w0 = wr_cnt;
        bus_start();
        write_byte(8'h2A, ack);
        write_byte(8'h06, ack);
        glitch_en = 1'b1;
        write_byte(8'h96, ack);
        glitch_en = 1'b0;
        check("R10 ack despite spikes", 32'(ack), 1);
        check("R10 one write", 32'(wr_cnt - w0), 1);
        check("R10 data intact", 32'({w_addr, w_data}), 16'h0696);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read_ptr();
        t_read_fresh();
        t_soft_rst();
        t_mismatch();
        t_stop_partial();
        t_rep_start();
        t_glitch();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule